// File: doc/BRIEF.md
# Paged DMA Address Translation Unit

This block turns bus addresses issued by a DMA-capable device into system addresses. It looks each address up in a table of 64-bit entries held in on-chip RAM, one entry per I/O page. The page size is a power of two chosen at run time through a shift. A window is defined by three values: a base offset, the page shift and an entry count. A request that falls inside the window returns the page-aligned I/O address, the translated page address, the in-page offset mask and the access rights. A request outside the window returns a no-access result rather than a fault.

Software loads the table through a write port, fetches single entries through a read port, and opens and closes the window with enable and disable commands. A clear command zeroes every entry in one cycle. Translation requests use a valid/ready handshake. Results come back on a fixed two-cycle pipeline: one cycle for the synchronous RAM read, then one cycle for the registered result.

Top module: `dma_xlate_unit`

## Requirements
- R1: The entry index is (address − base) shifted right by the page shift. An address hits only if it is not below the base and its index is less than the entry count. The same rule applies to translation requests, software reads and software writes.
- R2: A translation miss returns rsp_perm = 0, rsp_xaddr = 0, rsp_iova = 0 and rsp_mask all ones.
- R3: A translation hit returns:
  - rsp_iova = (address − base) rounded down to the page;
  - rsp_xaddr = the low ADDR_W bits of the entry, rounded down to the page;
  - rsp_mask = page size − 1.
- R4: Rights are decoded from the entry. Entry bit 0 grants read and entry bit 1 grants write. rsp_perm carries read in bit 0 and write in bit 1. The codes are 0 = none, 1 = read-only, 2 = write-only and 3 = read-write, so an entry value of zero gives no access.
- R5: A request is accepted in a cycle where req_valid and req_ready are both high. Its result appears with rsp_valid exactly two clock edges later. One request can be accepted every cycle.
- R6: A software read (rd_valid) returns its result two edges later with rd_done high:
  - in the window: rd_err = 0 and rd_entry = the stored entry;
  - outside the window: rd_err = 1 and rd_entry = 0.
  A software read takes the shared lookup port, so req_ready is low in any cycle where rd_valid is high.
- R7: A write (wr_valid) stores wr_entry at the index of wr_ioba. An out-of-window write changes no entry. A lookup presented in the cycle after the write sees the new value.
- R8: An enable command loads base, shift and count only when all of the following hold:
  - the window is closed (count = 0);
  - the shift is between 12 and 24;
  - the count is between 1 and MAX_ENTRIES.
  Otherwise the command is ignored. In particular, enabling an open window leaves its settings unchanged.
- R9: Disable sets base, shift and count to zero and zeroes every entry. Disable takes priority over a simultaneous enable. After disable, every lookup misses until a new enable.
- R10: tbl_clear zeroes every entry in one cycle and leaves the window settings unchanged. A clear in the same cycle as a write wins over the write.
- R11: Immediately after reset:
  - rsp_valid and rd_done are low;
  - the window is closed, so every lookup misses;
  - all entries read as zero;
  - the page shift holds its default value of 12 with a base of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_cmd | input | 1 | Open the window with the values below |
| en_shift | input | 5 | Page shift for enable |
| en_base | input | ADDR_W | Window base offset for enable |
| en_count | input | CNT_W | Entry count for enable |
| dis_cmd | input | 1 | Close the window and zero the table |
| tbl_clear | input | 1 | Zero every entry |
| wr_valid | input | 1 | Software entry write |
| wr_ioba | input | ADDR_W | Bus address selecting the entry to write |
| wr_entry | input | ENTRY_W | Entry value to store |
| rd_valid | input | 1 | Software entry read |
| rd_ioba | input | ADDR_W | Bus address selecting the entry to read |
| rd_done | output | 1 | Software read result valid |
| rd_err | output | 1 | Software read was outside the window |
| rd_entry | output | ENTRY_W | Entry read, zero on error |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request can be accepted |
| req_addr | input | ADDR_W | Device bus address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_iova | output | ADDR_W | Page-aligned window-relative I/O address |
| rsp_xaddr | output | ADDR_W | Page-aligned translated address |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Access rights: bit 0 read, bit 1 write |

## Verification
A wrong window register or a mis-shifted index shows up at the ports two edges after the next lookup. It appears either as a hit that should miss, giving a non-zero rsp_perm with a finite mask, or as an entry taken from a neighbouring page. A stale valid flag after clear or disable shows up on the first read of that entry as non-zero data where zero is due. A broken ready/priority rule changes the rsp_valid/rd_done pattern in the cycle that is two edges later. The bench's model predicts every output on every clock, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/xlt_pkg.sv
`timescale 1ns/1ps
package xlt_pkg;
  localparam int SHIFT_W = 5;
  localparam logic [SHIFT_W-1:0] SHIFT_MIN = 5'd12;
  localparam logic [SHIFT_W-1:0] SHIFT_MAX = 5'd24;
  localparam logic [SHIFT_W-1:0] SHIFT_DEF = 5'd12;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RD   = 2'b01,
    PERM_WR   = 2'b10,
    PERM_RW   = 2'b11
  } xlt_perm_e;

  // Entry bit 0 grants read, bit 1 grants write.
  function automatic xlt_perm_e perm_of(input logic [1:0] rw_bits);
    case (rw_bits)
      2'b01:   return PERM_RD;
      2'b10:   return PERM_WR;
      2'b11:   return PERM_RW;
      default: return PERM_NONE;
    endcase
  endfunction

  function automatic logic shift_ok(input logic [SHIFT_W-1:0] s);
    return (s >= SHIFT_MIN) && (s <= SHIFT_MAX);
  endfunction
endpackage

// File: rtl/xlt_cfg.sv
`timescale 1ns/1ps
module xlt_cfg
  import xlt_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int MAX_ENTRIES = 64,
  parameter int CNT_W       = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_cmd,
  input  logic [SHIFT_W-1:0] en_shift,
  input  logic [ADDR_W-1:0]  en_base,
  input  logic [CNT_W-1:0]   en_count,
  input  logic               dis_cmd,
  output logic [ADDR_W-1:0]  win_base,
  output logic [SHIFT_W-1:0] win_shift,
  output logic [CNT_W-1:0]   win_count,
  output logic               win_live
);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_ENTRIES);

  logic en_accept;

  assign win_live  = (win_count != '0);
  assign en_accept = en_cmd && !dis_cmd && !win_live && shift_ok(en_shift)
                     && (en_count != '0) && (en_count <= CNT_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_base  <= '0;
      win_shift <= SHIFT_DEF;
      win_count <= '0;
    end else if (dis_cmd) begin
      win_base  <= '0;
      win_shift <= '0;
      win_count <= '0;
    end else if (en_accept) begin
      win_base  <= en_base;
      win_shift <= en_shift;
      win_count <= en_count;
    end
  end

  AST_LIVE_SHIFT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    win_live |-> shift_ok(win_shift)); // R8
  AST_REENABLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (win_live && en_cmd && !dis_cmd) |=> ($stable(win_base) && $stable(win_shift) && $stable(win_count))); // R8
  AST_DISABLE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> (!win_live && win_base == '0)); // R9
endmodule

// File: rtl/xlt_entry_ram.sv
`timescale 1ns/1ps
module xlt_entry_ram #(
  parameter int ENTRY_W = 64,
  parameter int IDX_W   = 6,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]   ent_ok;
  logic [ENTRY_W-1:0] mem_q;
  logic               ok_q;

  // Storage without reset; read-before-write on a same-index collision.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  // One flag per entry makes a whole-table clear a single-cycle event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_ok <= '0;
      ok_q   <= 1'b0;
    end else begin
      ok_q <= ent_ok[raddr];
      if (clr)     ent_ok <= '0;
      else if (we) ent_ok[waddr] <= 1'b1;
    end
  end

  assign rdata = ok_q ? mem_q : '0;

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ent_ok == '0)); // R10
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> ent_ok[$past(waddr)]); // R7
endmodule

// File: rtl/dma_xlate_unit.sv
`timescale 1ns/1ps
module dma_xlate_unit
  import xlt_pkg::*;
#(
  parameter int  ADDR_W      = 48,
  parameter int  ENTRY_W     = 64,
  parameter int  MAX_ENTRIES = 64,
  localparam int IDX_W       = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_cmd,
  input  logic [4:0]         en_shift,
  input  logic [ADDR_W-1:0]  en_base,
  input  logic [CNT_W-1:0]   en_count,
  input  logic               dis_cmd,
  input  logic               tbl_clear,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_ioba,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               rd_valid,
  input  logic [ADDR_W-1:0]  rd_ioba,
  output logic               rd_done,
  output logic               rd_err,
  output logic [ENTRY_W-1:0] rd_entry,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_xaddr,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm
);
  // Arithmetic helpers ---------------------------------------------------
  function automatic logic [ADDR_W-1:0] page_mask(input logic [SHIFT_W-1:0] s);
    return {ADDR_W{1'b1}} << s;
  endfunction

  // Window-relative address with the borrow in the top bit.
  function automatic logic [ADDR_W:0] win_rel(input logic [ADDR_W-1:0] a,
                                              input logic [ADDR_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  function automatic logic [ADDR_W-1:0] idx_of(input logic [ADDR_W:0] relb,
                                               input logic [SHIFT_W-1:0] s);
    return relb[ADDR_W-1:0] >> s;
  endfunction

  // Window configuration -------------------------------------------------
  logic [ADDR_W-1:0]  cfg_base;
  logic [SHIFT_W-1:0] cfg_shift;
  logic [CNT_W-1:0]   cfg_count;
  logic               cfg_live;

  xlt_cfg #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_cmd(en_cmd), .en_shift(en_shift), .en_base(en_base), .en_count(en_count),
    .dis_cmd(dis_cmd),
    .win_base(cfg_base), .win_shift(cfg_shift), .win_count(cfg_count), .win_live(cfg_live)
  );

  // Lookup port: software read has priority over translation -------------
  logic              req_fire;
  logic              lk_fire;
  logic [ADDR_W-1:0] lk_addr;
  logic [ADDR_W:0]   lk_relb;
  logic [ADDR_W-1:0] lk_idx;
  logic              lk_hit;

  assign req_ready = !rd_valid;
  assign req_fire  = req_valid && req_ready;
  assign lk_fire   = rd_valid || req_fire;
  assign lk_addr   = rd_valid ? rd_ioba : req_addr;
  assign lk_relb   = win_rel(lk_addr, cfg_base);
  assign lk_idx    = idx_of(lk_relb, cfg_shift);
  assign lk_hit    = !lk_relb[ADDR_W] && (lk_idx < ADDR_W'(cfg_count));

  // Write port ------------------------------------------------------------
  logic [ADDR_W:0]   wr_relb;
  logic [ADDR_W-1:0] wr_idx;
  logic              wr_hit;
  logic              ram_we;
  logic              ram_clr;

  assign wr_relb = win_rel(wr_ioba, cfg_base);
  assign wr_idx  = idx_of(wr_relb, cfg_shift);
  assign wr_hit  = !wr_relb[ADDR_W] && (wr_idx < ADDR_W'(cfg_count));
  assign ram_we  = wr_valid && wr_hit;
  assign ram_clr = tbl_clear || dis_cmd;

  logic [ENTRY_W-1:0] ram_rdata;

  xlt_entry_ram #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .clr(ram_clr), .we(ram_we),
    .waddr(wr_idx[IDX_W-1:0]), .wdata(wr_entry),
    .raddr(lk_idx[IDX_W-1:0]), .rdata(ram_rdata)
  );

  // Stage 1: context travelling alongside the RAM read --------------------
  logic               s1_vld;
  logic               s1_sw;
  logic               s1_hit;
  logic [ADDR_W-1:0]  s1_rel;
  logic [SHIFT_W-1:0] s1_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_sw    <= 1'b0;
      s1_hit   <= 1'b0;
      s1_rel   <= '0;
      s1_shift <= SHIFT_DEF;
    end else begin
      s1_vld   <= lk_fire;
      s1_sw    <= rd_valid;
      s1_hit   <= lk_hit;
      s1_rel   <= lk_relb[ADDR_W-1:0];
      s1_shift <= cfg_shift;
    end
  end

  // Stage 2: registered results -------------------------------------------
  logic [ADDR_W-1:0] s1_pmask;
  assign s1_pmask = page_mask(s1_shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_iova  <= '0;
      rsp_xaddr <= '0;
      rsp_mask  <= '1;
      rsp_perm  <= PERM_NONE;
      rd_done   <= 1'b0;
      rd_err    <= 1'b0;
      rd_entry  <= '0;
    end else begin
      rsp_valid <= s1_vld && !s1_sw;
      rd_done   <= s1_vld && s1_sw;
      if (s1_vld && s1_sw) begin
        rd_err   <= !s1_hit;
        rd_entry <= s1_hit ? ram_rdata : '0;
      end
      if (s1_vld && !s1_sw) begin
        if (s1_hit) begin
          rsp_iova  <= s1_rel & s1_pmask;
          rsp_xaddr <= ram_rdata[ADDR_W-1:0] & s1_pmask;
          rsp_mask  <= ~s1_pmask;
          rsp_perm  <= perm_of(ram_rdata[1:0]);
        end else begin
          rsp_iova  <= '0;
          rsp_xaddr <= '0;
          rsp_mask  <= '1;
          rsp_perm  <= PERM_NONE;
        end
      end
    end
  end

  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> ##2 rsp_valid); // R5
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ##2 (rd_done && !rsp_valid)); // R6
  AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_mask & (rsp_mask + 1'b1)) == '0)); // R3
  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (((rsp_iova | rsp_xaddr) & rsp_mask) == '0)); // R3
  AST_MISS_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (&rsp_mask)) |-> (rsp_perm == 2'b00 && rsp_xaddr == '0)); // R2
  AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_err) |-> (rd_entry == '0)); // R6
  AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> cfg_live); // R7
endmodule

// File: tb/dma_xlate_unit_test.sv
`timescale 1ns/1ps
module dma_xlate_unit_test;
  localparam int AW = 48;
  localparam int EW = 64;
  localparam int NMAX = 64;
  localparam int CW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          en_cmd, dis_cmd, tbl_clear, wr_valid, rd_valid, req_valid;
  logic [4:0]    en_shift;
  logic [AW-1:0] en_base, wr_ioba, rd_ioba, req_addr;
  logic [CW-1:0] en_count;
  logic [EW-1:0] wr_entry;
  logic          rd_done, rd_err, req_ready, rsp_valid;
  logic [EW-1:0] rd_entry;
  logic [AW-1:0] rsp_iova, rsp_xaddr, rsp_mask;
  logic [1:0]    rsp_perm;

  dma_xlate_unit #(.ADDR_W(AW), .ENTRY_W(EW), .MAX_ENTRIES(NMAX)) uut (
    .clk(clk), .rst_n(rst_n),
    .en_cmd(en_cmd), .en_shift(en_shift), .en_base(en_base), .en_count(en_count),
    .dis_cmd(dis_cmd), .tbl_clear(tbl_clear),
    .wr_valid(wr_valid), .wr_ioba(wr_ioba), .wr_entry(wr_entry),
    .rd_valid(rd_valid), .rd_ioba(rd_ioba), .rd_done(rd_done), .rd_err(rd_err), .rd_entry(rd_entry),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_xaddr(rsp_xaddr),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm)
  );

  int    nchk = 0;
  int    nfail = 0;
  string phase = "R11 reset";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL [%s] %s: actual %h expected %h", phase, tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic          v;
    logic          sw;
    logic          err;
    logic [63:0]   data;
    logic [AW-1:0] iova;
    logic [AW-1:0] xa;
    logic [AW-1:0] mask;
    logic [1:0]    perm;
  } exp_t;

  logic [63:0]   mmem [NMAX];
  int unsigned   mcnt;
  logic [4:0]    msh;
  logic [AW-1:0] mbase;
  exp_t          e_mid, e_out;

  function automatic bit m_hit(input logic [AW-1:0] a, output int unsigned idx);
    logic [63:0] rel, pg;
    idx = 0;
    if (a < mbase) return 1'b0;
    rel = 64'(a) - 64'(mbase);
    pg  = 64'd1 << msh;
    if ((rel / pg) >= 64'(mcnt)) return 1'b0;
    idx = int'(rel / pg);
    return 1'b1;
  endfunction

  function automatic exp_t predict(input bit sw, input logic [AW-1:0] a);
    exp_t r;
    int unsigned idx;
    logic [63:0] rel, pg, ent;
    r = '0;
    r.v = 1'b1;
    r.sw = sw;
    if (!m_hit(a, idx)) begin
      r.err = 1'b1;
      r.mask = '1;
      return r;
    end
    rel = 64'(a) - 64'(mbase);
    pg  = 64'd1 << msh;
    ent = mmem[idx] % (64'd1 << AW);
    r.data = mmem[idx];
    r.iova = AW'(rel - (rel % pg));
    r.xa   = AW'(ent - (ent % pg));
    r.mask = AW'(pg - 1);
    r.perm = {mmem[idx][1], mmem[idx][0]};
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NMAX; i++) mmem[i] = '0;
      mcnt = 0; msh = 5'd12; mbase = '0;
      e_mid = '0; e_out = '0;
    end else begin
      int unsigned widx;
      e_out = e_mid;
      if (rd_valid)       e_mid = predict(1'b1, rd_ioba);
      else if (req_valid) e_mid = predict(1'b0, req_addr);
      else                e_mid = '0;
      if (wr_valid && m_hit(wr_ioba, widx)) mmem[widx] = wr_entry;
      if (tbl_clear || dis_cmd)
        for (int i = 0; i < NMAX; i++) mmem[i] = '0;
      if (dis_cmd) begin
        mcnt = 0; msh = 5'd0; mbase = '0;
      end else if (en_cmd && mcnt == 0 && en_shift >= 5'd12 && en_shift <= 5'd24
                   && en_count >= 1 && en_count <= NMAX) begin
        mcnt = en_count; msh = en_shift; mbase = en_base;
      end
    end
  end

  // ---------------- comparison, away from the active edge ----------------
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(rsp_valid == 1'b0, "R11 rsp_valid in reset", 64'(rsp_valid), 0);
      chk(rd_done == 1'b0, "R11 rd_done in reset", 64'(rd_done), 0);
    end else begin
      chk(req_ready == !rd_valid, "R6 req_ready", 64'(req_ready), 64'(!rd_valid));
      chk(rsp_valid == (e_out.v && !e_out.sw), "R5 rsp_valid", 64'(rsp_valid), 64'(e_out.v && !e_out.sw));
      chk(rd_done == (e_out.v && e_out.sw), "R6 rd_done", 64'(rd_done), 64'(e_out.v && e_out.sw));
      if (e_out.v && !e_out.sw && rsp_valid) begin
        if (e_out.err) begin
          chk(rsp_xaddr == '0 && rsp_iova == '0, "R2 miss address", {rsp_iova[31:0], rsp_xaddr[31:0]}, 0);
          chk(rsp_mask == e_out.mask, "R2 miss mask", 64'(rsp_mask), 64'(e_out.mask));
          chk(rsp_perm == 2'b00, "R2 miss perm", 64'(rsp_perm), 0);
        end else begin
          chk(rsp_iova == e_out.iova, "R3 iova", 64'(rsp_iova), 64'(e_out.iova));
          chk(rsp_xaddr == e_out.xa, "R3 xaddr", 64'(rsp_xaddr), 64'(e_out.xa));
          chk(rsp_mask == e_out.mask, "R3 mask", 64'(rsp_mask), 64'(e_out.mask));
          chk(rsp_perm == e_out.perm, "R4 perm", 64'(rsp_perm), 64'(e_out.perm));
        end
      end
      if (e_out.v && e_out.sw && rd_done) begin
        chk(rd_err == e_out.err, "R6 rd_err", 64'(rd_err), 64'(e_out.err));
        chk(rd_entry == e_out.data, "R6 rd_entry", rd_entry, e_out.data);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle_inputs();
    en_cmd = 0; dis_cmd = 0; tbl_clear = 0; wr_valid = 0; rd_valid = 0; req_valid = 0;
    en_shift = '0; en_base = '0; en_count = '0;
    wr_ioba = '0; wr_entry = '0; rd_ioba = '0; req_addr = '0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle_inputs();
  endtask

  task automatic op_idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic op_en(input logic [4:0] s, input logic [AW-1:0] b, input logic [CW-1:0] c);
    step(); en_cmd = 1; en_shift = s; en_base = b; en_count = c;
  endtask
  task automatic op_dis();
    step(); dis_cmd = 1;
  endtask
  task automatic op_clr();
    step(); tbl_clear = 1;
  endtask
  task automatic op_wr(input logic [AW-1:0] a, input logic [EW-1:0] d);
    step(); wr_valid = 1; wr_ioba = a; wr_entry = d;
  endtask
  task automatic op_rd(input logic [AW-1:0] a);
    step(); rd_valid = 1; rd_ioba = a;
  endtask
  task automatic op_req(input logic [AW-1:0] a);
    step(); req_valid = 1; req_addr = a;
  endtask
  task automatic op_both(input logic [AW-1:0] ra, input logic [AW-1:0] qa);
    step(); rd_valid = 1; rd_ioba = ra; req_valid = 1; req_addr = qa;
  endtask

  localparam logic [AW-1:0] B0 = 48'h0000_0001_0000;

  initial begin
    rst_n = 0;
    idle_inputs();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    phase = "R11 reset";
    op_req(48'h1000); op_rd(48'h0); op_req(48'h0); op_idle(3);

    phase = "R8 enable";
    op_en(5'd11, B0, 7'd4); op_req(B0);
    op_en(5'd12, B0, 7'd0); op_req(B0);
    op_en(5'd12, B0, 7'd65); op_req(B0);
    op_en(5'd25, B0, 7'd4); op_req(B0);
    op_en(5'd12, B0, 7'd16); op_req(B0 + 48'h123); op_idle(2);

    phase = "R7 writes";
    for (int i = 0; i < 16; i++) begin
      op_wr(B0 + AW'(i) * 48'h1000 + AW'(i * 8),
            64'hF00D_0000_0000_0000 | (64'(i) * 64'h1_2345_6000) | 64'(i % 4));
      op_req(B0 + AW'(i) * 48'h1000 + 48'h7);
    end
    op_wr(B0 + 48'h10000, 64'hDEAD_BEEF);
    op_wr(B0 - 48'h1000, 64'hBAD0_0003);
    op_wr(B0 + 48'h10_0000, 64'hBAD1_0003);
    op_rd(B0 + 48'h0); op_rd(B0 + 48'hF000); op_rd(B0 + 48'h0FFF);
    op_wr(B0 + 48'h3000, 64'h0000_0000_ABCD_E002);
    op_both(B0 + 48'h3000, B0 + 48'h3FFF); op_idle(2);

    phase = "R4 perms";
    for (int i = 0; i < 4; i++) op_req(B0 + AW'(i) * 48'h1000 + 48'hABC);
    op_wr(B0 + 48'h5000, 64'h0);
    op_req(B0 + 48'h5010); op_idle(2);

    phase = "R1 window bounds";
    op_req(B0 - 48'h1);
    op_req(B0 + 48'hFFFF);
    op_req(B0 + 48'h10000);
    op_req(48'hFFFF_FFFF_FFFF);
    op_req(48'h0);
    op_rd(B0 - 48'h1); op_rd(B0 + 48'h10000); op_idle(2);

    phase = "R5 pipeline";
    for (int i = 15; i >= 0; i--) op_req(B0 + AW'(i) * 48'h1000 + AW'(i));
    op_both(B0, B0 + 48'h1000);
    op_req(B0 + 48'h2000);
    op_both(B0 + 48'h20000, B0 + 48'h4000); op_idle(3);

    phase = "R6 software read";
    op_rd(B0 + 48'h7777); op_rd(B0 + 48'hE000); op_rd(B0 + 48'h10001); op_idle(2);

    phase = "R8 enable";
    op_en(5'd20, 48'h0, 7'd64); op_req(B0 + 48'h1800); op_rd(B0 + 48'h2000); op_idle(2);

    phase = "R10 clear";
    step(); tbl_clear = 1; wr_valid = 1; wr_ioba = B0 + 48'h6000; wr_entry = 64'h3;
    op_rd(B0); op_rd(B0 + 48'h6000); op_req(B0 + 48'h2222); op_req(B0 + 48'hF000);
    op_wr(B0 + 48'h9000, 64'hCAFE_1001);
    op_req(B0 + 48'h9001); op_idle(2);

    phase = "R9 disable";
    step(); dis_cmd = 1; en_cmd = 1; en_shift = 5'd16; en_base = 48'h0; en_count = 7'd8;
    op_req(B0 + 48'h9001); op_rd(B0 + 48'h9000); op_req(48'h0);
    op_wr(B0 + 48'h9000, 64'h3);
    op_en(5'd16, 48'h400_0000, 7'd64);
    op_rd(48'h400_0000 + 48'h9_0000); op_rd(48'h400_0000);
    op_wr(48'h400_0000 + 48'h3F_0000, 64'h0000_0012_3456_7803);
    op_req(48'h400_0000 + 48'h3F_ABCD);
    op_req(48'h400_0000 + 48'h40_0000);
    op_dis();
    op_en(5'd24, 48'h0, 7'd3);
    op_wr(48'h200_0005, 64'h0000_00AB_CDEF_0001);
    op_req(48'h2FF_FFFF); op_req(48'h300_0000); op_rd(48'h200_0000);
    op_idle(3);

    phase = "R3 mixed";
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [63:0] span;
      logic [AW-1:0] a;
      r = $urandom_range(0, 99);
      span = (64'(mcnt) + 2) << msh;
      a = mbase - 48'h80 + AW'({$urandom, $urandom} % span);
      if (r < 55) op_req(a);
      else if (r < 67) op_rd(a);
      else if (r < 72) op_both(a, a ^ 48'h1000);
      else if (r < 92) op_wr(a, {$urandom, $urandom});
      else if (r < 93) op_clr();
      else if (r < 95) op_dis();
      else op_en(5'($urandom_range(11, 25)), AW'($urandom_range(0, 255)) << 20,
                 7'($urandom_range(0, 66)));
    end
    op_idle(4);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL [%s] watchdog expired: actual timeout expected completion", phase);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule